// File: doc/BRIEF.md
# Directory Home Controller for Coherence Units

This block is the home node of a directory-based coherence scheme covering a small set of coherence units. For every unit it keeps a state (invalid, shared or exclusive), a bit-vector of the requesters that hold a copy, and the identity of the current owner. Requesters send read misses and write misses over one valid/ready message channel. The same channel also carries invalidation acknowledgements and completion notices from owners. The controller answers on a registered response channel with data replies, forwards to the owner, invalidations and exclusivity grants.

A read miss is served from home unless the unit is held exclusively. In that case the miss is forwarded to the owner, which supplies the data, and the home later marks the unit shared. A write miss to a shared unit sends an invalidation to every other holder, one per cycle. The home then counts acknowledgements and grants exclusivity only after the last one arrives. A write miss to an exclusive unit is forwarded so that ownership moves to the new requester. A unit with a transaction in flight refuses further misses by holding ready low. Data payloads are not stored here.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every unit is invalid with an empty copyset and no transaction in flight, rsp_valid is low and req_ready is high.
- R2: A read miss (req_type 0) to an invalid unit produces a data reply (rsp_type 0) to the requester, with rsp_req equal to the requester. The unit becomes shared, and its copyset holds only that requester.
- R3: A read miss to a shared unit produces a data reply to the requester and adds the requester to the copyset.
- R4: A read miss to an exclusive unit produces a forward-read (rsp_type 1) to the owner, with rsp_req set to the requester. An owner-done message (req_type 3) for that unit then makes it shared with a copyset of the old owner and the requester.
- R5: A write miss (req_type 1) to a shared unit sends an invalidation (rsp_type 3) to each copyset member except the writer. They go out on consecutive cycles in ascending requester index, each with rsp_req set to the writer, and req_ready stays low while they are sent.
- R6: The acknowledgement count equals the number of invalidations sent. A grant (rsp_type 4) goes to the writer only when the last acknowledgement (req_type 2) arrives, and the unit becomes exclusive with the writer as sole holder. If the writer is the only member, the grant is sent at once with no invalidation.
- R7: A write miss to an invalid unit produces an immediate grant to the requester and makes it the exclusive owner.
- R8: A write miss to an exclusive unit produces a forward-write (rsp_type 2) to the owner, with rsp_req set to the requester. An owner-done for that unit then makes the requester the owner and sole holder.
- R9: While a unit has a transaction in flight, misses to that unit see req_ready low, and misses to other units are still accepted.
- R10: An acknowledgement or owner-done message with no matching transaction in flight is consumed, produces no response and changes no unit.
- R11: Every accepted read miss yields its response in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming message valid |
| req_ready | output | 1 | Controller can accept the message |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 invalidation ack, 3 owner done |
| req_src | input | RW | Sending requester index |
| req_blk | input | BW | Coherence unit index |
| rsp_valid | output | 1 | Outgoing message valid (one-cycle pulse) |
| rsp_type | output | 3 | 0 data, 1 forward-read, 2 forward-write, 3 invalidate, 4 grant |
| rsp_dst | output | RW | Destination requester |
| rsp_blk | output | BW | Coherence unit index |
| rsp_req | output | RW | Requester on whose behalf the message is sent |

## Verification
A corrupted copyset shows up at the ports as a wrong set or order of invalidations on the next write miss to that unit. A lost owner shows up as a forward sent to the wrong destination on the next miss. An acknowledgement counter that is off by one makes the grant arrive one acknowledgement early or never arrive, which leaves the expected-response queue unbalanced at the end. A stuck in-flight flag holds req_ready low on that unit from the next cycle, and an early clear lets a second miss through while a forward is still outstanding.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2
  } unit_state_t;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_FRD  = 2'd1,
    PK_FWR  = 2'd2,
    PK_ACK  = 2'd3
  } pend_kind_t;

  localparam logic [1:0] MSG_RD    = 2'd0;
  localparam logic [1:0] MSG_WR    = 2'd1;
  localparam logic [1:0] MSG_ACK   = 2'd2;
  localparam logic [1:0] MSG_ODONE = 2'd3;

  localparam logic [2:0] RSP_DATA  = 3'd0;
  localparam logic [2:0] RSP_FRD   = 3'd1;
  localparam logic [2:0] RSP_FWR   = 3'd2;
  localparam logic [2:0] RSP_INV   = 3'd3;
  localparam logic [2:0] RSP_GRANT = 3'd4;

endpackage

// File: rtl/coh_lowbit.sv
module coh_lowbit #(
  parameter int NUM = 4,
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0] vec,
  output logic [IW-1:0]  idx,
  output logic           found
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/coh_inv_seq.sv
module coh_inv_seq #(
  parameter int NUM_REQ = 4,
  parameter int NUM_BLK = 8,
  localparam int RW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int BW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [NUM_REQ-1:0] load_mask,
  input  logic [BW-1:0]      load_blk,
  input  logic [RW-1:0]      load_writer,
  output logic               emit,
  output logic [RW-1:0]      emit_dst,
  output logic [BW-1:0]      emit_blk,
  output logic [RW-1:0]      emit_writer
);
  logic [NUM_REQ-1:0] mask_q;
  logic [BW-1:0]      blk_q;
  logic [RW-1:0]      writer_q;

  coh_lowbit #(.NUM(NUM_REQ)) pick_i (
    .vec  (mask_q),
    .idx  (emit_dst),
    .found(emit)
  );

  assign emit_blk    = blk_q;
  assign emit_writer = writer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      blk_q    <= '0;
      writer_q <= '0;
    end else if (load) begin
      mask_q   <= load_mask;
      blk_q    <= load_blk;
      writer_q <= load_writer;
    end else if (emit) begin
      mask_q[emit_dst] <= 1'b0;
    end
  end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_BLK = 8,
  localparam int RW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int BW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int CW = $clog2(NUM_REQ + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [RW-1:0] req_src,
  input  logic [BW-1:0] req_blk,
  output logic          rsp_valid,
  output logic [2:0]    rsp_type,
  output logic [RW-1:0] rsp_dst,
  output logic [BW-1:0] rsp_blk,
  output logic [RW-1:0] rsp_req
);
  // directory entries
  unit_state_t        dir_st  [NUM_BLK];
  logic [NUM_REQ-1:0] dir_cp  [NUM_BLK];
  logic [RW-1:0]      dir_own [NUM_BLK];
  pend_kind_t         dir_pk  [NUM_BLK];
  logic [RW-1:0]      dir_pr  [NUM_BLK];
  logic [CW-1:0]      dir_ac  [NUM_BLK];

  // addressed entry
  unit_state_t        ent_st;
  logic [NUM_REQ-1:0] ent_cp;
  logic [RW-1:0]      ent_own;
  pend_kind_t         ent_pk;
  logic [RW-1:0]      ent_pr;
  logic [CW-1:0]      ent_ac;

  logic [NUM_REQ-1:0] src_oh, own_oh, pr_oh, inv_mask;
  logic [CW-1:0]      inv_cnt;
  logic               is_miss, fire, seq_load;
  logic               seq_emit;
  logic [RW-1:0]      seq_dst, seq_writer;
  logic [BW-1:0]      seq_blk;

  always_comb begin
    ent_st  = dir_st[req_blk];
    ent_cp  = dir_cp[req_blk];
    ent_own = dir_own[req_blk];
    ent_pk  = dir_pk[req_blk];
    ent_pr  = dir_pr[req_blk];
    ent_ac  = dir_ac[req_blk];
    src_oh  = '0;
    src_oh[req_src] = 1'b1;
    own_oh  = '0;
    own_oh[ent_own] = 1'b1;
    pr_oh   = '0;
    pr_oh[ent_pr] = 1'b1;
    inv_mask = ent_cp & ~src_oh;
    inv_cnt  = '0;
    for (int i = 0; i < NUM_REQ; i++) inv_cnt = inv_cnt + CW'(inv_mask[i]);
  end

  assign is_miss   = (req_type == MSG_RD) || (req_type == MSG_WR);
  assign req_ready = !seq_emit && !(is_miss && ent_pk != PK_NONE);
  assign fire      = req_valid && req_ready;
  assign seq_load  = fire && req_type == MSG_WR && ent_st == ST_SHR && (|inv_mask);

  coh_inv_seq #(.NUM_REQ(NUM_REQ), .NUM_BLK(NUM_BLK)) inv_seq_i (
    .clk        (clk),
    .rst        (rst),
    .load       (seq_load),
    .load_mask  (inv_mask),
    .load_blk   (req_blk),
    .load_writer(req_src),
    .emit       (seq_emit),
    .emit_dst   (seq_dst),
    .emit_blk   (seq_blk),
    .emit_writer(seq_writer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BLK; b++) begin
        dir_st[b]  <= ST_INV;
        dir_cp[b]  <= '0;
        dir_own[b] <= '0;
        dir_pk[b]  <= PK_NONE;
        dir_pr[b]  <= '0;
        dir_ac[b]  <= '0;
      end
      rsp_valid <= 1'b0;
      rsp_type  <= RSP_DATA;
      rsp_dst   <= '0;
      rsp_blk   <= '0;
      rsp_req   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_blk   <= req_blk;
      if (seq_emit) begin
        rsp_valid <= 1'b1;
        rsp_type  <= RSP_INV;
        rsp_dst   <= seq_dst;
        rsp_blk   <= seq_blk;
        rsp_req   <= seq_writer;
      end else if (fire) begin
        case (req_type)
          MSG_RD: begin
            rsp_valid <= 1'b1;
            rsp_req   <= req_src;
            if (ent_st == ST_EXC) begin
              dir_pk[req_blk] <= PK_FRD;
              dir_pr[req_blk] <= req_src;
              rsp_type <= RSP_FRD;
              rsp_dst  <= ent_own;
            end else begin
              dir_st[req_blk] <= ST_SHR;
              dir_cp[req_blk] <= (ent_st == ST_INV) ? src_oh : (ent_cp | src_oh);
              rsp_type <= RSP_DATA;
              rsp_dst  <= req_src;
            end
          end
          MSG_WR: begin
            rsp_req <= req_src;
            if (ent_st == ST_EXC) begin
              dir_pk[req_blk] <= PK_FWR;
              dir_pr[req_blk] <= req_src;
              rsp_valid <= 1'b1;
              rsp_type  <= RSP_FWR;
              rsp_dst   <= ent_own;
            end else if (seq_load) begin
              dir_pk[req_blk] <= PK_ACK;
              dir_pr[req_blk] <= req_src;
              dir_ac[req_blk] <= inv_cnt;
            end else begin
              dir_st[req_blk]  <= ST_EXC;
              dir_own[req_blk] <= req_src;
              dir_cp[req_blk]  <= src_oh;
              rsp_valid <= 1'b1;
              rsp_type  <= RSP_GRANT;
              rsp_dst   <= req_src;
            end
          end
          MSG_ACK: begin
            if (ent_pk == PK_ACK) begin
              if (ent_ac == CW'(1)) begin
                dir_st[req_blk]  <= ST_EXC;
                dir_own[req_blk] <= ent_pr;
                dir_cp[req_blk]  <= pr_oh;
                dir_pk[req_blk]  <= PK_NONE;
                dir_ac[req_blk]  <= '0;
                rsp_valid <= 1'b1;
                rsp_type  <= RSP_GRANT;
                rsp_dst   <= ent_pr;
                rsp_req   <= ent_pr;
              end else begin
                dir_ac[req_blk] <= ent_ac - CW'(1);
              end
            end
          end
          default: begin
            if (ent_pk == PK_FRD) begin
              dir_st[req_blk] <= ST_SHR;
              dir_cp[req_blk] <= own_oh | pr_oh;
              dir_pk[req_blk] <= PK_NONE;
            end else if (ent_pk == PK_FWR) begin
              dir_own[req_blk] <= ent_pr;
              dir_cp[req_blk]  <= pr_oh;
              dir_pk[req_blk]  <= PK_NONE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk #(
  parameter int NUM_REQ = 4,
  parameter int NUM_BLK = 8,
  localparam int RW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CW = $clog2(NUM_REQ + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_type,
  input logic               rsp_valid,
  input logic [2:0]         rsp_type,
  input logic [RW-1:0]      rsp_dst,
  input logic [RW-1:0]      rsp_req,
  input logic [1:0]         cur_state,
  input logic [NUM_REQ-1:0] cur_copy,
  input logic [RW-1:0]      cur_owner,
  input logic [1:0]         cur_pend,
  input logic [CW-1:0]      cur_acnt
);
  logic [NUM_REQ-1:0] owner_oh;
  always_comb begin
    owner_oh = '0;
    owner_oh[cur_owner] = 1'b1;
  end

  // R1: reset leaves the response channel quiet
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !rsp_valid);

  // R1: an invalid unit has no holders and nothing in flight
  assert_invalid_empty_R1: assert property (@(posedge clk) disable iff (rst)
    cur_state == 2'd0 |-> (cur_copy == '0 && cur_pend == 2'd0));

  // R11: an accepted read miss answers next cycle with data or forward-read
  assert_read_answer_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_type == 2'd0) |=>
      (rsp_valid && (rsp_type == 3'd0 || rsp_type == 3'd1)));

  // R5: an invalidation never targets the writer
  assert_inv_not_writer_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_type == 3'd3) |-> rsp_dst != rsp_req);

  // R6: an exclusive unit has exactly its owner as holder
  assert_exclusive_single_R6: assert property (@(posedge clk) disable iff (rst)
    cur_state == 2'd2 |-> cur_copy == owner_oh);

  // R6: a unit waiting for acknowledgements has a nonzero count
  assert_ack_count_live_R6: assert property (@(posedge clk) disable iff (rst)
    cur_pend == 2'd3 |-> cur_acnt != '0);
endmodule

bind coh_home_dir coh_home_dir_chk #(.NUM_REQ(NUM_REQ), .NUM_BLK(NUM_BLK)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_type (req_type),
  .rsp_valid(rsp_valid),
  .rsp_type (rsp_type),
  .rsp_dst  (rsp_dst),
  .rsp_req  (rsp_req),
  .cur_state(ent_st),
  .cur_copy (ent_cp),
  .cur_owner(ent_own),
  .cur_pend (ent_pk),
  .cur_acnt (ent_ac)
);

// File: tb/coh_home_dir_tb.sv
module coh_home_dir_tb_top;
  localparam int NUM_REQ = 4;
  localparam int NUM_BLK = 8;
  localparam int RW = 2;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_type = '0;
  logic [RW-1:0] req_src = '0;
  logic [BW-1:0] req_blk = '0;
  logic          rsp_valid;
  logic [2:0]    rsp_type;
  logic [RW-1:0] rsp_dst;
  logic [BW-1:0] rsp_blk;
  logic [RW-1:0] rsp_req;

  always #5 clk = ~clk;

  coh_home_dir #(.NUM_REQ(NUM_REQ), .NUM_BLK(NUM_BLK)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_src(req_src), .req_blk(req_blk),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_dst(rsp_dst),
    .rsp_blk(rsp_blk), .rsp_req(rsp_req)
  );

  typedef struct packed {
    logic [2:0]    t;
    logic [RW-1:0] d;
    logic [BW-1:0] b;
    logic [RW-1:0] r;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] t, input int d, input int b, input int r, input string tag);
    exp_t e;
    e.t = t; e.d = RW'(d); e.b = BW'(b); e.r = RW'(r);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [1:0] typ, input int src, input int blk);
    @(negedge clk);
    req_valid = 1'b1; req_type = typ; req_src = RW'(src); req_blk = BW'(blk);
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic probe_blocked(input logic [1:0] typ, input int src, input int blk, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_type = typ; req_src = RW'(src); req_blk = BW'(blk);
    #1;
    chk(req_ready == 1'b0, tag, int'(req_ready), 0);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (!rst && rsp_valid && !done) begin
      exp_t  got;
      exp_t  e;
      string tg;
      got = {rsp_type, rsp_dst, rsp_blk, rsp_req};
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected response", int'(got), -1);
      end else begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(got == e, tg, int'(got), int'(e));
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);

    // R2 read miss to invalid unit, R11 answer timing
    push(3'd0, 0, 0, 0, "R2 data from home");
    send(2'd0, 0, 0);
    chk(rsp_valid == 1'b1, "R11 reply one cycle after handshake", int'(rsp_valid), 1);
    // R3 more readers join
    push(3'd0, 2, 0, 2, "R3 data to second reader");
    send(2'd0, 2, 0);
    push(3'd0, 3, 0, 3, "R3 data to third reader");
    send(2'd0, 3, 0);
    // R10 stray messages ignored
    send(2'd2, 1, 0);
    send(2'd3, 1, 0);
    // R5 write miss on shared: invalidate 0 then 3, writer 2 excluded
    push(3'd3, 0, 0, 2, "R5 first invalidation");
    push(3'd3, 3, 0, 2, "R5 second invalidation");
    send(2'd1, 2, 0);
    chk(req_ready == 1'b0, "R5 ready low during invalidations", int'(req_ready), 0);
    send(2'd2, 0, 0);
    idle(2);
    chk(exp_q.size() == 0, "R6 no grant before last ack", exp_q.size(), 0);
    push(3'd4, 2, 0, 2, "R6 grant after last ack");
    send(2'd2, 3, 0);

    // R4 read miss to exclusive unit forwards to owner 2
    push(3'd1, 2, 0, 1, "R4 forward-read to owner");
    send(2'd0, 1, 0);
    probe_blocked(2'd0, 0, 0, "R9 read blocked while in flight");
    probe_blocked(2'd1, 3, 0, "R9 write blocked while in flight");
    push(3'd0, 3, 1, 3, "R9 other unit still served");
    send(2'd0, 3, 1);
    send(2'd2, 0, 0);  // R10 ack while forward in flight
    send(2'd3, 2, 0);
    // R4 copyset is now {1,2}
    push(3'd3, 1, 0, 0, "R4 holder 1 invalidated");
    push(3'd3, 2, 0, 0, "R4 holder 2 invalidated");
    send(2'd1, 0, 0);
    send(2'd2, 1, 0);
    push(3'd4, 0, 0, 0, "R6 grant to writer 0");
    send(2'd2, 2, 0);

    // R8 write miss to exclusive unit
    push(3'd1 + 3'd1, 0, 0, 3, "R8 forward-write to owner");
    send(2'd1, 3, 0);
    send(2'd3, 0, 0);
    push(3'd1, 3, 0, 1, "R8 new owner receives forward");
    send(2'd0, 1, 0);
    send(2'd3, 3, 0);
    push(3'd3, 3, 0, 1, "R4 only other holder invalidated");
    send(2'd1, 1, 0);
    push(3'd4, 1, 0, 1, "R6 single ack grant");
    send(2'd2, 3, 0);

    // R7 write miss to invalid unit
    push(3'd4, 1, 2, 1, "R7 immediate grant");
    send(2'd1, 1, 2);
    // R6 writer is sole holder: grant at once
    push(3'd4, 3, 1, 3, "R6 grant with no invalidation");
    send(2'd1, 3, 1);
    // R10 stray ack leaves unit 1 exclusive to 3
    send(2'd2, 0, 1);
    push(3'd1, 3, 1, 2, "R10 owner unchanged after stray ack");
    send(2'd0, 2, 1);
    send(2'd3, 3, 1);

    idle(6);
    chk(exp_q.size() == 0, "R6 all expected responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule